// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two N-bit unsigned operands one bit per clock. It uses a single full adder, a carry flip-flop and two right-shifting registers. The low ends of the two registers feed the adder. The sum bit goes into the top of the first register, so that register holds the result once the addition is finished. The second register takes fresh data at its top end from an external serial input while its operand shifts out.

A parallel load fills both registers and starts a new addition. The host then holds the shift enable high. A counter counts the enabled shifts. After exactly N of them it raises a done flag, and the carry flip-flop then holds the carry out of the whole sum. While done is high, further shift requests are ignored, so the result stays put until the next load.

Top module: `serial_adder`

## Requirements
- R1: After reset, both registers, the carry flip-flop and the done flag read 0.
- R2: When `load_en` is high on a clock edge, `reg_a` takes `load_a` and `reg_b` takes `load_b`. On the same edge the carry flip-flop and the shift counter clear, so `carry` and `done` read 0 afterwards. This holds whatever the value of `shift_en`.
- R3: On an edge with `shift_en` high, `load_en` low and `done` low, `reg_a` shifts right by one. Its bit N-1 becomes the XOR of `reg_a[0]`, `reg_b[0]` and `carry`.
- R4: On such an edge, `carry` becomes the majority of `reg_a[0]`, `reg_b[0]` and the old `carry`.
- R5: On such an edge, `reg_b` shifts right by one and `ser_in` enters at bit N-1.
- R6: On an edge with both `shift_en` and `load_en` low, `reg_a`, `reg_b`, `carry` and `done` keep their values.
- R7: `done` rises after exactly N enabled shifts following a load or reset. At that point `reg_a` equals (A+B) mod 2^N and `carry` equals bit N of A+B.
- R8: While `done` is high, `shift_en` has no effect: `reg_a`, `reg_b` and `carry` hold until the next load.
- R9: `ser_out` always equals bit 0 of `reg_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Enables one serial add step |
| load_en | input | 1 | Parallel load of both operands; wins over shift |
| ser_in | input | 1 | Serial data entering the top of register B |
| load_a | input | N | Parallel value for register A |
| load_b | input | N | Parallel value for register B |
| ser_out | output | 1 | Low bit of register A |
| reg_a | output | N | Contents of register A (sum at the end) |
| reg_b | output | N | Contents of register B |
| carry | output | 1 | Carry flip-flop |
| done | output | 1 | High after N enabled shifts |

## Verification
The bench goes after the carry chain with operands of all ones, so a design that lost or delayed the carry would give a wrong sum and a wrong final carry. It gaps the shift enable with idle cycles. A counter that counted idle cycles would raise done early, and registers that moved while idle would corrupt the operands. It issues a load with the shift enable high, which exposes a reversed priority. It keeps shifting after done, which catches a design that runs past N bits and destroys the result.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } sa_op_e;
endpackage

// File: rtl/sa_full_adder.sv
module sa_full_adder (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    always_comb begin
        sum  = a ^ b ^ cin;
        cout = (a & b) | (a & cin) | (b & cin);
    end
endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg
    import serial_adder_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sa_op_e       op,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] data;
    } sr_state_t;

    sr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD:  st_d.data = par_in;
            OP_SHIFT: st_d.data = {ser_in, st_q.data[W-1:1]};
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.data;

    // R5
    sr_shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_SHIFT |=> q[W-1] == $past(ser_in));
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import serial_adder_pkg::*;
#(
    parameter int N = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  sa_op_e op,
    input  logic   cout,
    output logic   carry,
    output logic   done
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N);

    typedef struct packed {
        logic          cy;
        logic [CW-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.cy  = 1'b0;
                st_d.cnt = '0;
            end
            OP_SHIFT: begin
                st_d.cy  = cout;
                st_d.cnt = st_q.cnt + 1'b1;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carry = st_q.cy;
    assign done  = (st_q.cnt == LAST);

    // R2
    ctrl_load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOAD |=> !carry && !done);
    // R7
    ctrl_done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(op) == OP_SHIFT);
endmodule

// File: rtl/serial_adder.sv
module serial_adder
    import serial_adder_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         load_en,
    input  logic         ser_in,
    input  logic [N-1:0] load_a,
    input  logic [N-1:0] load_b,
    output logic         ser_out,
    output logic [N-1:0] reg_a,
    output logic [N-1:0] reg_b,
    output logic         carry,
    output logic         done
);
    sa_op_e op;
    logic   sum_bit;
    logic   cout_bit;

    always_comb begin
        if (load_en)               op = OP_LOAD;
        else if (shift_en && !done) op = OP_SHIFT;
        else                       op = OP_HOLD;
    end

    sa_full_adder u_fa (
        .a    (reg_a[0]),
        .b    (reg_b[0]),
        .cin  (carry),
        .sum  (sum_bit),
        .cout (cout_bit)
    );

    sa_shift_reg #(.W(N)) u_reg_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .par_in (load_a),
        .ser_in (sum_bit),
        .q      (reg_a)
    );

    sa_shift_reg #(.W(N)) u_reg_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .par_in (load_b),
        .ser_in (ser_in),
        .q      (reg_b)
    );

    sa_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .cout  (cout_bit),
        .carry (carry),
        .done  (done)
    );

    assign ser_out = reg_a[0];

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> reg_a == $past(load_a) && reg_b == $past(load_b));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en && !shift_en |=> $stable(reg_a) && $stable(reg_b) && $stable(carry) && $stable(done));
    // R8
    done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !load_en |=> $stable(reg_a) && $stable(reg_b) && $stable(carry) && done);
    // R3
    sum_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && !load_en && !done |=>
            reg_a[N-1] == ($past(reg_a[0]) ^ $past(reg_b[0]) ^ $past(carry)));
endmodule

// File: tb/serial_adder_bench.sv
module serial_adder_bench;
    localparam int N = 4;
    localparam int MASK = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0;
    logic         load_en = 1'b0;
    logic         ser_in = 1'b0;
    logic [N-1:0] load_a = '0;
    logic [N-1:0] load_b = '0;
    logic         ser_out;
    logic [N-1:0] reg_a;
    logic [N-1:0] reg_b;
    logic         carry;
    logic         done;

    int n_chk = 0;
    int n_bad = 0;
    int ma = 0, mb = 0, mc = 0, mcnt = 0;

    always #2 clk = ~clk;

    serial_adder #(.N(N)) u_serial_adder (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load_en(load_en),
        .ser_in(ser_in), .load_a(load_a), .load_b(load_b), .ser_out(ser_out),
        .reg_a(reg_a), .reg_b(reg_b), .carry(carry), .done(done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "reg_a", int'(reg_a), ma);
        check(req, "reg_b", int'(reg_b), mb);
        check(req, "carry", int'(carry), mc);
        check("R7", "done", int'(done), (mcnt == N) ? 1 : 0);
        check("R9", "ser_out", int'(ser_out), ma & 1);
    endtask

    task automatic step(input string req, input bit sh, input bit ld, input bit si,
                        input int la, input int lb);
        @(negedge clk);
        shift_en = sh; load_en = ld; ser_in = si;
        load_a = N'(la); load_b = N'(lb);
        @(posedge clk);
        if (ld) begin
            ma = la & MASK; mb = lb & MASK; mc = 0; mcnt = 0;
        end else if (sh && mcnt < N) begin
            int s;
            s = (ma & 1) + (mb & 1) + mc;
            ma = (ma >> 1) | ((s & 1) << (N - 1));
            mb = (mb >> 1) | (int'(si) << (N - 1));
            mc = s >> 1;
            mcnt++;
        end
        #1;
        compare_all(req);
    endtask

    task automatic add(input int a, input int b, input bit gaps);
        step("R2", 1'b0, 1'b1, 1'b0, a, b);
        for (int i = 0; i < N; i++) begin
            step("R3", 1'b1, 1'b0, i[0], 0, 0);
            if (gaps) step("R6", 1'b0, 1'b0, 1'b1, 0, 0);
        end
        check("R7", "sum", int'(reg_a), (a + b) & MASK);
        check("R4", "carry out", int'(carry), ((a + b) >> N) & 1);
        check("R7", "done", int'(done), 1);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #7;
        compare_all("R1");
        rst_n = 1'b1;
        add(3, 5, 1'b0);
        add(15, 15, 1'b0);
        add(15, 1, 1'b1);
        add(0, 0, 1'b0);
        add(9, 6, 1'b1);
        // R8: shifting after done leaves the result untouched
        for (int i = 0; i < 3; i++) step("R8", 1'b1, 1'b0, 1'b1, 0, 0);
        // R2: load wins over shift
        step("R2", 1'b1, 1'b1, 1'b1, 10, 7);
        for (int i = 0; i < N; i++) step("R5", 1'b1, 1'b0, ~i[0], 0, 0);
        check("R7", "sum", int'(reg_a), (10 + 7) & MASK);
        for (int a = 0; a < 16; a += 5)
            for (int b = 1; b < 16; b += 6) add(a, b, (a + b) % 2 == 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule